// File: doc/BRIEF.md
# Last Number Redial Buffer

This block keeps a copy of the number dialled by hand on a telephone so that the number can be sent again with a single redial key. Every key code entered by hand while off-hook is written into a small store, and the store holds up to `DEPTH` entries. Digits and pause codes are kept exactly as they arrive. The first key entered by hand in a call starts a new number and replaces the old one. If more than `DEPTH` entries are keyed, the store marks itself inhibited, and redial stays blocked until a later number fits.

A redial key pressed as the very first key of a call makes the block replay the stored entries, in the order they were keyed, to the downstream dialler queue. The replay uses a valid/ready handshake and sends one entry per accepted transfer. Once a replay has started, further keys typed in that call are not written to the store, so the same number can be redialled again in later calls. The key stream also feeds the dialler queue directly, outside this block. For that reason, digits that are not stored still reach the line.

Top module: `lnr_buffer`

## Requirements
- R1: After power-on reset, `out_vld` and `inhibit` are low and the store is empty, so a redial produces no output.
- R2: While off-hook, each `key_vld` pulse stores its 4-bit `key_code` unchanged. Digits use codes 0 to 9 and the pause key uses code 12. Up to `DEPTH` (31) entries are held.
- R3: The first key entered by hand after going off-hook resets the stored length to zero before that key is written, so the new number replaces the old one.
- R4: Keying entry number `DEPTH+1` or later raises `inhibit` on the next cycle. While `inhibit` is high, redial is ignored. The first key of a later number clears `inhibit`.
- R5: Keys entered after a redial has started in the same call are not stored.
- R6: Redial can be repeated in any number of later calls and always replays the same entries.
- R7: A redial key is accepted only when it is the first key after off-hook, with no `key_vld` in the same cycle, a non-empty store and `inhibit` low. Otherwise it has no effect.
- R8: `out_vld` rises in the cycle after an accepted redial. Entry k is presented until a cycle with `q_rdy` high, and the entries leave in keyed order. `out_vld` falls after the last entry is accepted. `out_code` holds steady while `q_rdy` is low.
- R9: Going on-hook stops a replay: `out_vld` is low in the cycle after `off_hook` is sampled low.
- R10: A number of exactly `DEPTH` entries leaves `inhibit` low and is replayed in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; clears the store |
| off_hook | input | 1 | High while the handset is off-hook |
| key_vld | input | 1 | One-cycle strobe for a key entered by hand |
| key_code | input | 4 | Code of that key (0-9 digits, 12 pause) |
| redial_key | input | 1 | One-cycle strobe for the redial key |
| q_rdy | input | 1 | Downstream dialler queue can take an entry |
| out_vld | output | 1 | Replay entry is valid |
| out_code | output | 4 | Replay entry code |
| inhibit | output | 1 | Store overflowed; redial is blocked |

## Verification
A key or redial strobe driven before a rising edge is registered at that edge. Its effect, whether the stored length, `inhibit` or the start of `out_vld`, therefore shows on the ports one cycle later. The bench drives on the falling edge and reads flags on the next falling edge. Replay entries are due one per rising edge that sees `out_vld` and `q_rdy` both high. A monitor samples shortly after each falling edge, once the inputs for the coming edge are settled, and pops the expected code from a scoreboard queue for every transfer. Any transfer with nothing expected in the queue is counted as a miscompare. A call dropped on-hook must show `out_vld` low one cycle later.

// File: rtl/lnr_pkg.sv
`timescale 1ns/1ps
package lnr_pkg;

  typedef enum logic [1:0] {
    SES_FRESH  = 2'd0,
    SES_MANUAL = 2'd1,
    SES_LOCKED = 2'd2
  } ses_state_t;

  function automatic int unsigned len_after_key(int unsigned len,
                                                bit restart,
                                                int unsigned depth);
    if (restart)          return 1;
    else if (len < depth) return len + 1;
    else                  return len;
  endfunction

  function automatic bit ovf_after_key(bit ovf,
                                       int unsigned len,
                                       bit restart,
                                       int unsigned depth);
    if (restart)           return 1'b0;
    else if (len >= depth) return 1'b1;
    else                   return ovf;
  endfunction

  function automatic int unsigned write_slot(int unsigned len, bit restart);
    return restart ? 0 : len;
  endfunction

  function automatic bit is_last(int unsigned ptr, int unsigned len);
    return (len != 0) && (ptr == len - 1);
  endfunction

endpackage

// File: rtl/lnr_session.sv
`timescale 1ns/1ps
module lnr_session
  import lnr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       off_hook,
  input  logic       key_vld,
  input  logic       redial_key,
  input  logic       store_nonempty,
  input  logic       store_inhibit,
  output logic       wr_en,
  output logic       restart,
  output logic       redial_go,
  output logic       locked
);

  ses_state_t state_q;

  always_comb begin
    restart   = off_hook && key_vld && (state_q == SES_FRESH);
    wr_en     = off_hook && key_vld && (state_q != SES_LOCKED);
    redial_go = off_hook && redial_key && !key_vld &&
                (state_q == SES_FRESH) && store_nonempty && !store_inhibit;
    locked    = (state_q == SES_LOCKED);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SES_FRESH;
    end else if (!off_hook) begin
      state_q <= SES_FRESH;
    end else if (redial_go) begin
      state_q <= SES_LOCKED;
    end else if (key_vld && state_q == SES_FRESH) begin
      state_q <= SES_MANUAL;
    end
  end

endmodule

// File: rtl/lnr_store.sv
`timescale 1ns/1ps
module lnr_store
  import lnr_pkg::*;
#(
  parameter int unsigned DEPTH  = 31,
  parameter int unsigned CODE_W = 4,
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              restart,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [LEN_W-1:0]  rd_idx,
  output logic [CODE_W-1:0] rd_code,
  output logic [LEN_W-1:0]  len,
  output logic              inhibit
);

  logic [LEN_W-1:0]  len_q;
  logic              ovf_q;
  logic [LEN_W-1:0]  slot;
  logic              slot_ok;
  logic [CODE_W-1:0] cell_q [DEPTH];

  always_comb begin
    slot    = LEN_W'(write_slot(int'(len_q), restart));
    slot_ok = wr_en && (restart || (int'(len_q) < int'(DEPTH)));
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[g] <= '0;
      end else if (slot_ok && slot == LEN_W'(g)) begin
        cell_q[g] <= wr_code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      ovf_q <= 1'b0;
    end else if (wr_en) begin
      len_q <= LEN_W'(len_after_key(int'(len_q), restart, DEPTH));
      ovf_q <= ovf_after_key(ovf_q, int'(len_q), restart, DEPTH);
    end
  end

  always_comb begin
    rd_code = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == LEN_W'(i)) rd_code = cell_q[i];
    end
  end

  assign len     = len_q;
  assign inhibit = ovf_q;

endmodule

// File: rtl/lnr_replay.sv
`timescale 1ns/1ps
module lnr_replay
  import lnr_pkg::*;
#(
  parameter int unsigned DEPTH  = 31,
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             off_hook,
  input  logic             redial_go,
  input  logic [LEN_W-1:0] len,
  input  logic             q_rdy,
  output logic [LEN_W-1:0] rd_idx,
  output logic             active,
  output logic             fire
);

  logic [LEN_W-1:0] ptr_q;
  logic             act_q;
  logic             at_end;

  always_comb begin
    fire   = act_q && q_rdy;
    at_end = is_last(int'(ptr_q), int'(len));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ptr_q <= '0;
    end else if (!off_hook) begin
      act_q <= 1'b0;
      ptr_q <= '0;
    end else if (redial_go) begin
      act_q <= 1'b1;
      ptr_q <= '0;
    end else if (fire) begin
      if (at_end) begin
        act_q <= 1'b0;
        ptr_q <= '0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign rd_idx = ptr_q;
  assign active = act_q;

endmodule

// File: rtl/lnr_buffer.sv
`timescale 1ns/1ps
module lnr_buffer
  import lnr_pkg::*;
#(
  parameter int unsigned DEPTH  = 31,
  parameter int unsigned CODE_W = 4,
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              off_hook,
  input  logic              key_vld,
  input  logic [CODE_W-1:0] key_code,
  input  logic              redial_key,
  input  logic              q_rdy,
  output logic              out_vld,
  output logic [CODE_W-1:0] out_code,
  output logic              inhibit
);

  logic             wr_en;
  logic             restart;
  logic             redial_go;
  logic             locked;
  logic             fire;
  logic [LEN_W-1:0] store_len;
  logic [LEN_W-1:0] rd_idx;
  logic             store_nonempty;

  assign store_nonempty = (store_len != '0);

  lnr_session u_session (
    .clk            (clk),
    .rst_n          (rst_n),
    .off_hook       (off_hook),
    .key_vld        (key_vld),
    .redial_key     (redial_key),
    .store_nonempty (store_nonempty),
    .store_inhibit  (inhibit),
    .wr_en          (wr_en),
    .restart        (restart),
    .redial_go      (redial_go),
    .locked         (locked)
  );

  lnr_store #(.DEPTH(DEPTH), .CODE_W(CODE_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .restart (restart),
    .wr_code (key_code),
    .rd_idx  (rd_idx),
    .rd_code (out_code),
    .len     (store_len),
    .inhibit (inhibit)
  );

  lnr_replay #(.DEPTH(DEPTH)) u_replay (
    .clk       (clk),
    .rst_n     (rst_n),
    .off_hook  (off_hook),
    .redial_go (redial_go),
    .len       (store_len),
    .q_rdy     (q_rdy),
    .rd_idx    (rd_idx),
    .active    (out_vld),
    .fire      (fire)
  );

endmodule

// File: rtl/lnr_buffer_chk.sv
`timescale 1ns/1ps
module lnr_buffer_chk #(
  parameter int unsigned DEPTH  = 31,
  parameter int unsigned CODE_W = 4,
  localparam int unsigned LEN_W = $clog2(DEPTH + 1)
)(
  input logic              clk,
  input logic              rst_n,
  input logic              off_hook,
  input logic              key_vld,
  input logic              q_rdy,
  input logic              out_vld,
  input logic [CODE_W-1:0] out_code,
  input logic              inhibit,
  input logic              wr_en,
  input logic              restart,
  input logic              redial_go,
  input logic              locked,
  input logic [LEN_W-1:0]  store_len
);

  p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    store_len <= LEN_W'(DEPTH));

  p_restart_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (store_len == LEN_W'(1)));

  p_inhibit_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> !redial_go);

  p_no_store_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !wr_en);

  p_len_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(store_len));

  p_accept_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redial_go |=> locked);

  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redial_go |=> out_vld);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !q_rdy && off_hook) |=> (out_vld && $stable(out_code)));

  p_onhook_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !off_hook |=> !out_vld);

  p_inhibit_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (store_len == LEN_W'(DEPTH)));

endmodule

bind lnr_buffer lnr_buffer_chk #(.DEPTH(DEPTH), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .off_hook  (off_hook),
  .key_vld   (key_vld),
  .q_rdy     (q_rdy),
  .out_vld   (out_vld),
  .out_code  (out_code),
  .inhibit   (inhibit),
  .wr_en     (wr_en),
  .restart   (restart),
  .redial_go (redial_go),
  .locked    (locked),
  .store_len (store_len)
);

// File: tb/lnr_buffer_test.sv
`timescale 1ns/1ps
module lnr_buffer_test;

  localparam int DEPTH = 31;
  localparam logic [3:0] PAUSE = 4'd12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       off_hook = 1'b0;
  logic       key_vld = 1'b0;
  logic [3:0] key_code = '0;
  logic       redial_key = 1'b0;
  logic       q_rdy = 1'b0;
  logic       out_vld;
  logic [3:0] out_code;
  logic       inhibit;

  int n_chk = 0;
  int n_bad = 0;
  int rdy_mode = 0;
  int rdy_cnt = 0;
  bit done = 1'b0;
  logic [3:0] sb [$];
  string sb_tag [$];

  always #2.5 clk = ~clk;

  lnr_buffer uut (
    .clk(clk), .rst_n(rst_n), .off_hook(off_hook), .key_vld(key_vld),
    .key_code(key_code), .redial_key(redial_key), .q_rdy(q_rdy),
    .out_vld(out_vld), .out_code(out_code), .inhibit(inhibit)
  );

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ready pattern: 0 always high, 1 alternating, 2 always low
  always @(negedge clk) begin
    rdy_cnt <= rdy_cnt + 1;
    case (rdy_mode)
      0: q_rdy <= 1'b1;
      1: q_rdy <= rdy_cnt[0];
      default: q_rdy <= 1'b0;
    endcase
  end

  // monitor: sample after the falling edge, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_vld && q_rdy) begin
        if (sb.size() == 0) begin
          check("R8 unexpected transfer", out_code, 4'hx);
        end else begin
          check(sb_tag.pop_front(), out_code, sb.pop_front());
        end
      end
    end
  end

  task automatic press(logic [3:0] c);
    @(negedge clk);
    key_vld = 1'b1; key_code = c;
    @(negedge clk);
    key_vld = 1'b0;
  endtask

  task automatic redial();
    @(negedge clk);
    redial_key = 1'b1;
    @(negedge clk);
    redial_key = 1'b0;
  endtask

  task automatic new_call();
    @(negedge clk); off_hook = 1'b0;
    @(negedge clk); @(negedge clk); off_hook = 1'b1;
    @(negedge clk);
  endtask

  task automatic expect_seq(logic [3:0] seq [$], string tag);
    foreach (seq[i]) begin sb.push_back(seq[i]); sb_tag.push_back(tag); end
  endtask

  task automatic drain(string tag);
    int guard = 0;
    while (sb.size() != 0 && guard < 500) begin @(negedge clk); guard++; end
    check({tag, " queue drained"}, 4'(sb.size()), 4'd0);
    repeat (2) @(negedge clk);
    check({tag, " out_vld low after replay"}, {3'b0, out_vld}, 4'd0);
  endtask

  initial begin
    logic [3:0] s1 [$];
    logic [3:0] s2 [$];
    logic [3:0] s3 [$];
    repeat (3) @(negedge clk);
    check("R1 out_vld at reset", {3'b0, out_vld}, 4'd0);
    check("R1 inhibit at reset", {3'b0, inhibit}, 4'd0);
    rst_n = 1'b1;
    off_hook = 1'b1;
    redial();
    repeat (3) @(negedge clk);
    check("R1 empty store redial ignored", {3'b0, out_vld}, 4'd0);

    // R2: digits and a pause are stored verbatim; R8 with stalls
    press(4'd1); press(4'd2); press(PAUSE); press(4'd3);
    new_call();
    rdy_mode = 1;
    s1 = '{4'd1, 4'd2, PAUSE, 4'd3};
    expect_seq(s1, "R2 R8 replay order");
    redial();
    check("R8 out_vld after redial", {3'b0, out_vld}, 4'd1);
    // R5: post-dialled keys while replaying are not stored
    press(4'd7); press(4'd8);
    drain("R8");

    // R6: repeat redial in a later call gives the same number
    new_call();
    rdy_mode = 0;
    expect_seq(s1, "R5 R6 repeated redial");
    redial();
    drain("R6");

    // R7 and R3: redial after a key is ignored; new number overwrites
    new_call();
    press(4'd9); press(4'd4);
    redial();
    repeat (3) @(negedge clk);
    check("R7 late redial ignored", {3'b0, out_vld}, 4'd0);
    new_call();
    s2 = '{4'd9, 4'd4};
    expect_seq(s2, "R3 overwrite");
    redial();
    drain("R3");

    // R10: exactly DEPTH entries
    new_call();
    s3 = {};
    for (int i = 0; i < DEPTH; i++) begin
      press(4'(i % 10));
      s3.push_back(4'(i % 10));
    end
    check("R10 inhibit low at full", {3'b0, inhibit}, 4'd0);
    new_call();
    expect_seq(s3, "R10 full replay");
    redial();
    drain("R10");

    // R4: one more than DEPTH inhibits
    new_call();
    for (int i = 0; i < DEPTH; i++) press(4'd5);
    check("R4 inhibit low at DEPTH", {3'b0, inhibit}, 4'd0);
    press(4'd6);
    check("R4 inhibit after overflow", {3'b0, inhibit}, 4'd1);
    new_call();
    redial();
    repeat (3) @(negedge clk);
    check("R4 redial ignored while inhibited", {3'b0, out_vld}, 4'd0);
    check("R4 inhibit held", {3'b0, inhibit}, 4'd1);
    new_call();
    press(4'd6);
    check("R4 inhibit cleared by new number", {3'b0, inhibit}, 4'd0);
    press(4'd6);
    new_call();
    s2 = '{4'd6, 4'd6};
    expect_seq(s2, "R4 short number after overflow");
    redial();
    drain("R4");

    // R9: on-hook aborts replay (no transfers, ready held low)
    new_call();
    rdy_mode = 2;
    redial();
    check("R9 replay started", {3'b0, out_vld}, 4'd1);
    off_hook = 1'b0;
    @(negedge clk);
    check("R9 out_vld after on-hook", {3'b0, out_vld}, 4'd0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule